// File: doc/BRIEF.md
# Watchdog Timer with Single or Paired Service Strobes

This block is a watchdog counter that asks for a system reset when software stops servicing it. Each restart sets the count to zero. The count then advances on ticks from one of three sources, chosen by a static configuration input: the system clock divided by a fixed prescale, a slow real-time tick, or the tick of a dedicated watchdog oscillator. When the count reaches a parameterised limit, the block raises a one-cycle reset request, sets a timeout status flag and begins again from zero.

Servicing has two configured forms. In the first, a single service strobe restarts the count. In the second, two distinct strobes must both arrive, in either order, before the count restarts. Each strobe of the pair is remembered in its own pending bit until the restart. The instruction decoder is not part of this block; it is represented only by these strobes.

The block also tracks low-power halt. Entering halt sets a power-down flag and clears the timeout flag. While halted, ticks taken from the divided system clock are gated off, so the count freezes. Ticks from the real-time source or the watchdog oscillator keep counting. When the watchdog oscillator is the source, halt entry also zeroes the count. A timeout while halted becomes a one-cycle wake pulse instead of a reset request.

Top module: `wdt_guard`

## Requirements
- R1: While rst_n is low, rst_req, wake_req, to_flag, pd_flag and halted are all 0.
- R2: With src_sel = 0 (system clock divided by DIV, DIV = 4), rst_req rises exactly DIV*LIMIT clock edges after the last restart (or reset release), stays high for one cycle, and to_flag is 1 from that edge.
- R3: With src_sel = 1, the count advances once per cycle in which rtc_tick is high, and the LIMIT-th tick after a restart raises rst_req.
- R4: With src_sel = 2, the count advances on osc_tick, and the LIMIT-th tick after a restart raises rst_req.
- R5: With dual_mode = 0, a clr_cmd pulse restarts the count at the edge that samples it, and clr_a and clr_b have no effect.
- R6: With dual_mode = 1, the count restarts only at the edge by which both clr_a and clr_b have been seen since the last restart, in either order; clr_cmd and a single strobe alone have no effect.
- R7: In dual_mode, both pending strobes are forgotten at each restart, so one later strobe alone does not restart the count.
- R8: While halted with src_sel = 0, the count and prescaler hold their values, no timeout occurs and service strobes are ignored; a wake_in pulse ends halt and counting resumes from the held value.
- R9: A halt_enter pulse while not halted sets halted and pd_flag and clears to_flag at the next edge; with src_sel = 2 it also zeroes the count.
- R10: With src_sel = 1, halt entry leaves the count unchanged and ticks keep advancing it during halt.
- R11: A timeout while halted gives a one-cycle wake_req pulse instead of rst_req, sets to_flag and clears halted.
- R12: A completed service clears both to_flag and pd_flag.
- R13: After a timeout the count restarts from zero, so the next timeout follows a full period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Tick source: 0 divided system clock, 1 real-time tick, 2 watchdog oscillator, 3 none |
| dual_mode | input | 1 | 1 = paired service strobes required, 0 = single strobe |
| rtc_tick | input | 1 | One-cycle pulse from the slow real-time source |
| osc_tick | input | 1 | One-cycle pulse from the watchdog oscillator |
| clr_cmd | input | 1 | Single service strobe |
| clr_a | input | 1 | First strobe of the pair |
| clr_b | input | 1 | Second strobe of the pair |
| halt_enter | input | 1 | Pulse requesting entry into halt |
| wake_in | input | 1 | Pulse ending halt from another wake source |
| rst_req | output | 1 | One-cycle system reset request on timeout |
| wake_req | output | 1 | One-cycle wake pulse on timeout during halt |
| to_flag | output | 1 | Timeout status |
| pd_flag | output | 1 | Power-down status |
| halted | output | 1 | Block is in halt state |

## Verification
Every strobe (service, halt entry, wake, source tick) takes effect at the clock edge that samples it. Because all outputs are registered, the result can be seen in the cycle that follows that edge. A timeout appears LIMIT ticks after a restart, which is DIV*LIMIT edges for the divided-clock source. The driver stamps each expected value with the absolute edge number it derives from these counts, including the edges held frozen in halt. The monitor compares each value on the falling edge of exactly that cycle. Expectations are also placed on the edges where a wrong restart (a lone strobe, an ignored command, a missing clear at halt entry) would have put an early reset request.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
   typedef enum logic [1:0] {
      SRC_SYSDIV = 2'd0,
      SRC_RTC    = 2'd1,
      SRC_OSC    = 2'd2,
      SRC_NONE   = 2'd3
   } wdt_src_e;
endpackage

// File: rtl/wdt_guard_tick.sv
// Tick source selection and system-clock prescaler.
module wdt_guard_tick #(
   parameter int DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] src_sel,
   input  logic       rtc_tick,
   input  logic       osc_tick,
   input  logic       halted,
   input  logic       restart,
   output logic       tick_en
);
   import wdt_guard_pkg::*;

   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] PTOP = PW'(DIV - 1);

   logic [PW-1:0] presc;
   logic          sys_tick;

   assign sys_tick = (presc == PTOP);

   generate
      if ((DIV & (DIV - 1)) == 0) begin : g_pow2
         // power-of-two divider wraps by itself
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       presc <= '0;
            else if (restart) presc <= '0;
            else if (!halted) presc <= presc + 1'b1;
         end
      end else begin : g_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       presc <= '0;
            else if (restart) presc <= '0;
            else if (!halted) presc <= sys_tick ? '0 : presc + 1'b1;
         end
      end
   endgenerate

   always_comb begin
      case (wdt_src_e'(src_sel))
         SRC_SYSDIV: tick_en = sys_tick && !halted;
         SRC_RTC:    tick_en = rtc_tick;
         SRC_OSC:    tick_en = osc_tick;
         default:    tick_en = 1'b0;
      endcase
   end
endmodule

// File: rtl/wdt_guard_clear.sv
// Service strobe handling: single strobe or an unordered pair.
module wdt_guard_clear (
   input  logic clk,
   input  logic rst_n,
   input  logic dual_mode,
   input  logic clr_cmd,
   input  logic clr_a,
   input  logic clr_b,
   input  logic inhibit,
   input  logic restart,
   output logic service
);
   logic pend_a, pend_b;
   logic got_a, got_b;

   assign got_a = pend_a || (clr_a && !inhibit);
   assign got_b = pend_b || (clr_b && !inhibit);

   assign service = !inhibit && (dual_mode ? (got_a && got_b) : clr_cmd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_a <= 1'b0;
         pend_b <= 1'b0;
      end else if (restart || !dual_mode) begin
         pend_a <= 1'b0;
         pend_b <= 1'b0;
      end else begin
         pend_a <= got_a;
         pend_b <= got_b;
      end
   end
endmodule

// File: rtl/wdt_guard.sv
// Watchdog counter with halt tracking and status flags.
module wdt_guard #(
   parameter int LIMIT = 32768,
   parameter int DIV   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] src_sel,
   input  logic       dual_mode,
   input  logic       rtc_tick,
   input  logic       osc_tick,
   input  logic       clr_cmd,
   input  logic       clr_a,
   input  logic       clr_b,
   input  logic       halt_enter,
   input  logic       wake_in,
   output logic       rst_req,
   output logic       wake_req,
   output logic       to_flag,
   output logic       pd_flag,
   output logic       halted
);
   import wdt_guard_pkg::*;

   localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CNT_W-1:0] TERM = CNT_W'(LIMIT - 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("wdt_guard: LIMIT must be at least 2");
      end
      if (DIV < 2) begin : g_bad_div
         $error("wdt_guard: DIV must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             tick_en;
   logic             service;
   logic             timeout;
   logic             entering;
   logic             src_osc;
   logic             restart;

   assign src_osc  = (wdt_src_e'(src_sel) == SRC_OSC);
   assign entering = halt_enter && !halted;
   assign timeout  = tick_en && (cnt == TERM);
   assign restart  = entering ? src_osc : (service || timeout);

   wdt_guard_tick #(.DIV(DIV)) i_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_sel  (src_sel),
      .rtc_tick (rtc_tick),
      .osc_tick (osc_tick),
      .halted   (halted),
      .restart  (restart),
      .tick_en  (tick_en)
   );

   wdt_guard_clear i_clear (
      .clk       (clk),
      .rst_n     (rst_n),
      .dual_mode (dual_mode),
      .clr_cmd   (clr_cmd),
      .clr_a     (clr_a),
      .clr_b     (clr_b),
      .inhibit   (halted || halt_enter),
      .restart   (restart),
      .service   (service)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         halted   <= 1'b0;
         rst_req  <= 1'b0;
         wake_req <= 1'b0;
         to_flag  <= 1'b0;
         pd_flag  <= 1'b0;
      end else begin
         rst_req  <= 1'b0;
         wake_req <= 1'b0;
         if (entering) begin
            halted  <= 1'b1;
            pd_flag <= 1'b1;
            to_flag <= 1'b0;
            if (src_osc) cnt <= '0;
         end else if (service) begin
            // service in the same cycle as a timeout wins
            cnt     <= '0;
            to_flag <= 1'b0;
            pd_flag <= 1'b0;
         end else if (timeout) begin
            cnt     <= '0;
            to_flag <= 1'b1;
            if (halted) begin
               wake_req <= 1'b1;
               halted   <= 1'b0;
            end else begin
               rst_req <= 1'b1;
            end
         end else begin
            if (halted && wake_in) halted <= 1'b0;
            if (tick_en) cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/wdt_guard_chk.sv
// Temporal checks on the watchdog, attached by bind.
module wdt_guard_chk #(
   parameter int CNT_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       src_sel,
   input logic             halt_enter,
   input logic             halted,
   input logic             rst_req,
   input logic             wake_req,
   input logic             to_flag,
   input logic             pd_flag,
   input logic [CNT_W-1:0] cnt
);
   p_rst_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   p_rst_sets_to_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> to_flag);

   p_restart_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt == '0));

   p_sys_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && src_sel == 2'd0) |=> $stable(cnt));

   p_halt_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_enter && !halted) |=> (halted && pd_flag && !to_flag));

   p_no_rst_in_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> !rst_req);

   p_wake_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !wake_req);

   p_wake_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (!halted && to_flag && !rst_req));
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_sel    (src_sel),
   .halt_enter (halt_enter),
   .halted     (halted),
   .rst_req    (rst_req),
   .wake_req   (wake_req),
   .to_flag    (to_flag),
   .pd_flag    (pd_flag),
   .cnt        (cnt)
);

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
   localparam int LIM = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] src_sel = 2'd0;
   logic       dual_mode = 1'b0;
   logic       rtc_tick = 1'b0, osc_tick = 1'b0;
   logic       clr_cmd = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
   logic       halt_enter = 1'b0, wake_in = 1'b0;
   logic       rst_req, wake_req, to_flag, pd_flag, halted;

   always #10 clk = ~clk;

   wdt_guard #(.LIMIT(LIM), .DIV(4)) i_wdt_guard (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .dual_mode(dual_mode),
      .rtc_tick(rtc_tick), .osc_tick(osc_tick), .clr_cmd(clr_cmd),
      .clr_a(clr_a), .clr_b(clr_b), .halt_enter(halt_enter), .wake_in(wake_in),
      .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag),
      .pd_flag(pd_flag), .halted(halted)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    at;
      int    sig;
      logic  val;
      string tag;
   } exp_t;
   exp_t sb[$];

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   function automatic logic probe(int s);
      case (s)
         0: return rst_req;
         1: return wake_req;
         2: return to_flag;
         3: return pd_flag;
         default: return halted;
      endcase
   endfunction

   function automatic string sname(int s);
      case (s)
         0: return "rst_req";
         1: return "wake_req";
         2: return "to_flag";
         3: return "pd_flag";
         default: return "halted";
      endcase
   endfunction

   task automatic judge(int s, logic v, string tag);
      n_chk++;
      if (probe(s) !== v) begin
         n_err++;
         $display("FAIL %s: %s actual=%0b expected=%0b (cycle %0d)",
                  tag, sname(s), probe(s), v, cyc);
      end
   endtask

   // driver side: queue an expectation dt edges ahead
   task automatic expect_at(int dt, int s, logic v, string tag);
      exp_t e;
      e.at = cyc + dt; e.sig = s; e.val = v; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compare due expectations away from the active edge
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].at == cyc) begin
            judge(sb[i].sig, sb[i].val, sb[i].tag);
            sb.delete(i);
         end
      end
   end

   task automatic step(int n);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   // 0 clr_cmd, 1 clr_a, 2 clr_b, 3 halt_enter, 4 wake_in, 5 rtc_tick, 6 osc_tick
   task automatic set_strobe(int w, logic v);
      case (w)
         0: clr_cmd = v;
         1: clr_a = v;
         2: clr_b = v;
         3: halt_enter = v;
         4: wake_in = v;
         5: rtc_tick = v;
         default: osc_tick = v;
      endcase
   endtask

   task automatic pulse(int w);
      set_strobe(w, 1'b1);
      step(1);
      set_strobe(w, 1'b0);
   endtask

   task automatic ticks(int w, int n);
      repeat (n) begin
         pulse(w);
         step(1);
      end
   endtask

   task automatic do_reset(logic [1:0] s, logic d);
      rst_n = 1'b0;
      src_sel = s;
      dual_mode = d;
      for (int w = 0; w < 7; w++) set_strobe(w, 1'b0);
      step(2);
      rst_n = 1'b1;
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         report();
      end
   end

   initial begin
      step(1);
      // R1: reset state
      rst_n = 1'b0;
      step(2);
      for (int s = 0; s < 5; s++) judge(s, 1'b0, "R1");

      // R2, R13: divided system clock, free running
      do_reset(2'd0, 1'b0);
      expect_at(31, 0, 1'b0, "R2");
      expect_at(32, 0, 1'b1, "R2");
      expect_at(32, 2, 1'b1, "R2");
      expect_at(33, 0, 1'b0, "R2");
      expect_at(63, 0, 1'b0, "R13");
      expect_at(64, 0, 1'b1, "R13");
      step(66);

      // R5: single clear restarts, pair strobes ignored
      do_reset(2'd0, 1'b0);
      step(20);
      expect_at(12, 0, 1'b0, "R5");
      expect_at(32, 0, 1'b0, "R5");
      expect_at(33, 0, 1'b1, "R5");
      pulse(0);
      step(8);
      pulse(1);
      pulse(2);
      step(40);

      // R6: dual clear, a then ignored clr_cmd then b
      do_reset(2'd0, 1'b1);
      step(10);
      pulse(1);
      step(5);
      pulse(0);
      step(5);
      expect_at(10, 0, 1'b0, "R6");
      expect_at(21, 0, 1'b0, "R6");
      expect_at(27, 0, 1'b0, "R6");
      expect_at(32, 0, 1'b0, "R6");
      expect_at(33, 0, 1'b1, "R6");
      pulse(2);
      step(40);

      // R6: reverse order, b then a
      do_reset(2'd0, 1'b1);
      step(10);
      pulse(2);
      step(9);
      expect_at(12, 0, 1'b0, "R6");
      expect_at(23, 0, 1'b0, "R6");
      expect_at(32, 0, 1'b0, "R6");
      expect_at(33, 0, 1'b1, "R6");
      pulse(1);
      step(40);

      // R7: pending bits forgotten at restart
      do_reset(2'd0, 1'b1);
      step(10);
      pulse(1);
      step(4);
      pulse(2);
      step(4);
      expect_at(27, 0, 1'b0, "R7");
      expect_at(28, 0, 1'b1, "R7");
      pulse(1);
      step(35);

      // R8: halt freezes divided-clock counting, clears ignored
      do_reset(2'd0, 1'b0);
      step(10);
      expect_at(1, 4, 1'b1, "R9");
      expect_at(1, 3, 1'b1, "R9");
      expect_at(1, 2, 1'b0, "R9");
      expect_at(22, 0, 1'b0, "R8");
      pulse(3);
      step(19);
      pulse(0);
      step(29);
      expect_at(1, 4, 1'b0, "R8");
      expect_at(3, 0, 1'b0, "R8");
      expect_at(10, 3, 1'b1, "R8");
      expect_at(21, 0, 1'b0, "R8");
      expect_at(22, 0, 1'b1, "R8");
      pulse(4);
      step(25);

      // R4: oscillator source timeout
      do_reset(2'd2, 1'b0);
      ticks(6, 7);
      judge(0, 1'b0, "R4");
      expect_at(1, 0, 1'b1, "R4");
      expect_at(1, 2, 1'b1, "R4");
      pulse(6);
      step(1);
      // R9: halt entry zeroes oscillator count, flags update
      ticks(6, 5);
      expect_at(1, 4, 1'b1, "R9");
      expect_at(1, 3, 1'b1, "R9");
      expect_at(1, 2, 1'b0, "R9");
      pulse(3);
      step(1);
      ticks(6, 7);
      judge(4, 1'b1, "R9");
      // R11: timeout in halt wakes
      expect_at(1, 1, 1'b1, "R11");
      expect_at(1, 0, 1'b0, "R11");
      expect_at(1, 2, 1'b1, "R11");
      expect_at(1, 4, 1'b0, "R11");
      expect_at(2, 1, 1'b0, "R11");
      expect_at(2, 0, 1'b0, "R11");
      pulse(6);
      step(2);
      // R12: service clears both status flags
      judge(3, 1'b1, "R12");
      expect_at(1, 2, 1'b0, "R12");
      expect_at(1, 3, 1'b0, "R12");
      pulse(0);
      step(2);

      // R3: real-time tick source
      do_reset(2'd1, 1'b0);
      ticks(5, 7);
      judge(0, 1'b0, "R3");
      expect_at(1, 0, 1'b1, "R3");
      pulse(5);
      step(1);
      // R10: real-time count kept and advancing through halt
      ticks(5, 3);
      pulse(3);
      step(1);
      ticks(5, 4);
      judge(4, 1'b1, "R10");
      expect_at(1, 1, 1'b1, "R10");
      expect_at(1, 4, 1'b0, "R10");
      pulse(5);
      step(3);

      done = 1'b1;
      report();
   end
endmodule